// File: doc/BRIEF.md
# RGB to YUV Colour-Space Matrix

This block turns a stream of 10-bit red, green and blue samples into 10-bit luma (Y) and two colour-difference components (U, V). It accepts one sample triple per clock, qualified by a valid strobe. Each output is a fixed-point weighted sum of the three inputs. The coefficients are signed integers scaled by 4096, which gives 12 fractional bits.

Both colour-difference outputs carry a mid-scale offset of 512, so a grey input lands at the centre of the code range. Every result is rounded to the nearest integer and then saturated to the 10-bit range 0..1023. A group of sync sideband bits travels alongside the samples and is delayed by the same three clocks as the arithmetic, so timing markers stay aligned with the pixels they belong to.

When the input strobe is low, the data registers keep their contents, so the output values stay frozen until new valid data arrives.

Top module: `rgb2yuv_conv`

## Requirements
- R1: While reset is asserted and until the first result arrives, out_valid, out_sync, out_y, out_u and out_v are all zero.
- R2: Y = (1225·R + 2404·G + 467·B + 2048) >> 12 (arithmetic shift), then saturated; a grey input R=G=B=x gives Y = x exactly.
- R3: U = ((−705·R − 1389·G + 2093·B + 512·4096 + 2048) >> 12), then saturated.
- R4: V = ((2093·R − 1753·G − 340·B + 512·4096 + 2048) >> 12), then saturated.
- R5: Rounding is to nearest, with halves rounded upward: 2048 is added to the sum before the 12-bit shift. For example, R=2 with G=B=0 gives Y=1.
- R6: A result below 0 becomes 0, and a result above 1023 becomes 1023. For example, R=G=0 with B=1023 gives U=1023, and R=G=1023 with B=0 gives U=0.
- R7: out_valid equals in_valid from exactly 3 clocks earlier.
- R8: out_sync equals in_sync from exactly 3 clocks earlier, whatever the state of in_valid.
- R9: A sample presented with in_valid low changes no data output; out_y, out_u and out_v keep the result of the last valid sample.
- R10: A grey input (R=G=B) gives U and V within 1 LSB of 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input triple is valid |
| in_sync | input | SYNC_W (3) | Sync sideband bits aligned with the input |
| in_r | input | DATA_W (10) | Red sample, unsigned |
| in_g | input | DATA_W (10) | Green sample, unsigned |
| in_b | input | DATA_W (10) | Blue sample, unsigned |
| out_valid | output | 1 | Output triple is valid |
| out_sync | output | SYNC_W (3) | Delayed sync sideband bits |
| out_y | output | DATA_W (10) | Luma |
| out_u | output | DATA_W (10) | Blue colour difference, offset by 512 |
| out_v | output | DATA_W (10) | Red colour difference, offset by 512 |

## Verification
The valid bit, the sync bits and every data result presented before a rising edge become visible after the third rising edge that follows. The bench therefore drives inputs on falling edges. On each falling edge it compares the outputs against a model entry recorded three steps earlier; before three steps have elapsed, it compares them against the reset values. For steps that carry an invalid sample, the model keeps its previous data, which checks the hold behaviour at the same point in the pipeline. The checker compares out_valid and out_sync with the inputs from three edges earlier, but only once three edges have passed since reset.

// File: rtl/rgb2yuv_pkg.sv
package rgb2yuv_pkg;

    localparam int PIPE_LAT = 3;
    localparam int FRAC_W   = 12;
    localparam int COEF_W   = 14;
    localparam int ROWS     = 3;

    // Matrix coefficients, scaled by 2**FRAC_W; row 0 = Y, 1 = U, 2 = V
    function automatic logic signed [COEF_W-1:0] coef(input int row, input int col);
        int v;
        case (row)
            0: v = (col == 0) ? 1225 : (col == 1) ? 2404 : 467;
            1: v = (col == 0) ? -705 : (col == 1) ? -1389 : 2093;
            default: v = (col == 0) ? 2093 : (col == 1) ? -1753 : -340;
        endcase
        return COEF_W'(v);
    endfunction

    // Mid-scale offset applied to the colour-difference rows only
    function automatic int row_offset(input int row, input int data_w);
        return (row == 0) ? 0 : (1 << (data_w - 1));
    endfunction

endpackage

// File: rtl/csc_sideband.sv
module csc_sideband #(
    parameter int SYNC_W = 3,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SYNC_W-1:0] in_sync,
    output logic [LAT-1:0]    vld_tap,
    output logic [SYNC_W-1:0] sync_out
);

    typedef struct packed {
        logic [LAT-1:0]             vld;
        logic [LAT-1:0][SYNC_W-1:0] sync;
    } sb_t;

    sb_t sb_d, sb_q;

    always_comb begin
        sb_d      = sb_q;
        sb_d.vld  = {sb_q.vld[LAT-2:0], in_valid};
        sb_d.sync = {sb_q.sync[LAT-2:0], in_sync};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    assign vld_tap  = sb_q.vld;
    assign sync_out = sb_q.sync[LAT-1];

endmodule

// File: rtl/csc_row_mac.sv
module csc_row_mac #(
    parameter int DATA_W = 10,
    parameter int ROW    = 0,
    parameter int ACC_W  = 27
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_mul,
    input  logic                    en_sum,
    input  logic [DATA_W-1:0]       r_i,
    input  logic [DATA_W-1:0]       g_i,
    input  logic [DATA_W-1:0]       b_i,
    output logic signed [ACC_W-1:0] acc_o
);
    import rgb2yuv_pkg::*;

    localparam int PROD_W = DATA_W + 1 + COEF_W;
    localparam logic signed [COEF_W-1:0] K0 = coef(ROW, 0);
    localparam logic signed [COEF_W-1:0] K1 = coef(ROW, 1);
    localparam logic signed [COEF_W-1:0] K2 = coef(ROW, 2);
    // Offset in fixed point plus half an LSB for round-to-nearest
    localparam logic signed [ACC_W-1:0] BIAS =
        ACC_W'(row_offset(ROW, DATA_W) * (2 ** FRAC_W) + (2 ** (FRAC_W - 1)));

    typedef struct packed {
        logic signed [PROD_W-1:0] p0;
        logic signed [PROD_W-1:0] p1;
        logic signed [PROD_W-1:0] p2;
        logic signed [ACC_W-1:0]  sum;
    } mac_t;

    mac_t mac_d, mac_q;

    always_comb begin
        mac_d = mac_q;
        if (en_mul) begin
            mac_d.p0 = PROD_W'($signed({1'b0, r_i})) * PROD_W'(K0);
            mac_d.p1 = PROD_W'($signed({1'b0, g_i})) * PROD_W'(K1);
            mac_d.p2 = PROD_W'($signed({1'b0, b_i})) * PROD_W'(K2);
        end
        if (en_sum) begin
            mac_d.sum = ACC_W'(mac_q.p0) + ACC_W'(mac_q.p1) + ACC_W'(mac_q.p2) + BIAS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mac_q <= '0;
        else        mac_q <= mac_d;
    end

    assign acc_o = mac_q.sum;

endmodule

// File: rtl/csc_sat.sv
module csc_sat #(
    parameter int DATA_W = 10,
    parameter int ACC_W  = 27
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] acc_i,
    output logic [DATA_W-1:0]       dout
);
    import rgb2yuv_pkg::*;

    localparam logic signed [ACC_W-1:0] TOP = ACC_W'((2 ** DATA_W) - 1);

    logic signed [ACC_W-1:0] scaled;
    logic [DATA_W-1:0]       dout_d, dout_q;

    always_comb begin
        scaled = acc_i >>> FRAC_W;
        dout_d = dout_q;
        if (en) begin
            if (scaled[ACC_W-1])  dout_d = '0;
            else if (scaled > TOP) dout_d = '1;
            else                   dout_d = scaled[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout_q <= '0;
        else        dout_q <= dout_d;
    end

    assign dout = dout_q;

endmodule

// File: rtl/rgb2yuv_conv.sv
module rgb2yuv_conv #(
    parameter int DATA_W = 10,
    parameter int SYNC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SYNC_W-1:0] in_sync,
    input  logic [DATA_W-1:0] in_r,
    input  logic [DATA_W-1:0] in_g,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [SYNC_W-1:0] out_sync,
    output logic [DATA_W-1:0] out_y,
    output logic [DATA_W-1:0] out_u,
    output logic [DATA_W-1:0] out_v
);
    import rgb2yuv_pkg::*;

    localparam int ACC_W = DATA_W + 1 + COEF_W + 2;

    logic [PIPE_LAT-1:0]     vld_tap;
    logic signed [ACC_W-1:0] acc [ROWS];
    logic [DATA_W-1:0]       res [ROWS];

    csc_sideband #(
        .SYNC_W (SYNC_W),
        .LAT    (PIPE_LAT)
    ) u_sideband (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sync  (in_sync),
        .vld_tap  (vld_tap),
        .sync_out (out_sync)
    );

    for (genvar row = 0; row < ROWS; row++) begin : g_row
        csc_row_mac #(
            .DATA_W (DATA_W),
            .ROW    (row),
            .ACC_W  (ACC_W)
        ) u_mac (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_mul (in_valid),
            .en_sum (vld_tap[0]),
            .r_i    (in_r),
            .g_i    (in_g),
            .b_i    (in_b),
            .acc_o  (acc[row])
        );

        csc_sat #(
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
        ) u_sat (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (vld_tap[1]),
            .acc_i (acc[row]),
            .dout  (res[row])
        );
    end

    assign out_valid = vld_tap[PIPE_LAT-1];
    assign out_y     = res[0];
    assign out_u     = res[1];
    assign out_v     = res[2];

endmodule

// File: rtl/rgb2yuv_chk.sv
module rgb2yuv_chk #(
    parameter int DATA_W = 10,
    parameter int SYNC_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [SYNC_W-1:0] in_sync,
    input logic [DATA_W-1:0] in_r,
    input logic [DATA_W-1:0] in_g,
    input logic [DATA_W-1:0] in_b,
    input logic              out_valid,
    input logic [SYNC_W-1:0] out_sync,
    input logic [DATA_W-1:0] out_y,
    input logic [DATA_W-1:0] out_u,
    input logic [DATA_W-1:0] out_v
);
    localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));

    // Edges seen since reset release, saturating at 3
    logic [1:0] seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    logic grey_in;
    assign grey_in = (in_r == in_g) && (in_g == in_b);

    assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3) |-> (out_sync == $past(in_sync, 3)));

    assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen != 2'd0) && !out_valid) |-> ($stable(out_y) && $stable(out_u) && $stable(out_v)));

    assert_grey_luma_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen == 2'd3) && $past(in_valid, 3) && $past(grey_in, 3)) |-> (out_y == $past(in_r, 3)));

    assert_grey_chroma_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen == 2'd3) && $past(in_valid, 3) && $past(grey_in, 3)) |->
        ((out_u >= MID - DATA_W'(1)) && (out_u <= MID + DATA_W'(1)) &&
         (out_v >= MID - DATA_W'(1)) && (out_v <= MID + DATA_W'(1))));

endmodule

bind rgb2yuv_conv rgb2yuv_chk #(.DATA_W(DATA_W), .SYNC_W(SYNC_W)) u_chk (.*);

// File: tb/rgb2yuv_conv_bench.sv
`timescale 1ns/1ps
module rgb2yuv_conv_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_sync = '0;
    logic [9:0] in_r = '0, in_g = '0, in_b = '0;
    logic       out_valid;
    logic [2:0] out_sync;
    logic [9:0] out_y, out_u, out_v;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    rgb2yuv_conv u_rgb2yuv_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_sync(out_sync),
        .out_y(out_y), .out_u(out_u), .out_v(out_v)
    );

    // Reference from the requirement equations (R2..R6)
    function automatic int model(input int row, input int r, input int g, input int b);
        int acc;
        int q;
        case (row)
            0: acc = 1225*r + 2404*g + 467*b;
            1: acc = -705*r - 1389*g + 2093*b + 512*4096;
            default: acc = 2093*r - 1753*g - 340*b + 512*4096;
        endcase
        q = (acc + 2048) >>> 12;
        if (q < 0) q = 0;
        if (q > 1023) q = 1023;
        return q;
    endfunction

    int    n = 0;
    bit    hv [4];
    int    hs [4];
    int    hr [4], hg [4], hb [4];
    string htag [4];
    int    my = 0, mu = 0, mv = 0;

    task automatic step(input bit v, input int s, input int r, input int g, input int b,
                        input string tag);
        int    k;
        int    ev, es;
        string t;
        @(negedge clk);
        if (n >= 3) begin
            k  = (n - 3) % 4;
            ev = int'(hv[k]);
            es = hs[k];
            t  = htag[k];
            if (hv[k]) begin
                my = model(0, hr[k], hg[k], hb[k]);
                mu = model(1, hr[k], hg[k], hb[k]);
                mv = model(2, hr[k], hg[k], hb[k]);
            end
        end else begin
            ev = 0; es = 0; t = "R1";
        end
        total++;
        if (int'(out_valid) != ev || int'(out_sync) != es || int'(out_y) != my ||
            int'(out_u) != mu || int'(out_v) != mv) begin
            bad++;
            $display("FAIL %s step %0d: actual vld=%0d sync=%0d y=%0d u=%0d v=%0d expected vld=%0d sync=%0d y=%0d u=%0d v=%0d",
                     t, n, out_valid, out_sync, out_y, out_u, out_v, ev, es, my, mu, mv);
        end
        k = n % 4;
        hv[k] = v; hs[k] = s; hr[k] = r; hg[k] = g; hb[k] = b; htag[k] = tag;
        in_valid = v; in_sync = 3'(s);
        in_r = 10'(r); in_g = 10'(g); in_b = 10'(b);
        n++;
    endtask

    task automatic flush(input string tag);
        for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, 0, tag);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_sync !== 3'd0 || out_y !== 10'd0 ||
            out_u !== 10'd0 || out_v !== 10'd0) begin
            bad++;
            $display("FAIL R1 reset: actual vld=%0d sync=%0d y=%0d u=%0d v=%0d expected all 0",
                     out_valid, out_sync, out_y, out_u, out_v);
        end
        rst_n = 1'b1;
        step(1'b0, 0, 0, 0, 0, "R1");
        step(1'b0, 0, 0, 0, 0, "R1");
    endtask

    task automatic test_grey();
        step(1'b1, 0, 0, 0, 0, "R10");
        step(1'b1, 0, 1, 1, 1, "R10");
        step(1'b1, 0, 512, 512, 512, "R10");
        step(1'b1, 0, 1000, 1000, 1000, "R10");
        step(1'b1, 0, 1023, 1023, 1023, "R2");
        flush("R10");
    endtask

    task automatic test_matrix();
        step(1'b1, 0, 100, 200, 300, "R2");
        step(1'b1, 0, 300, 100, 50, "R3");
        step(1'b1, 0, 50, 300, 100, "R4");
        step(1'b1, 0, 2, 0, 0, "R5");
        step(1'b1, 0, 0, 0, 3, "R5");
        step(1'b1, 0, 700, 20, 400, "R3");
        step(1'b1, 0, 10, 900, 15, "R4");
        flush("R2");
    endtask

    task automatic test_saturate();
        step(1'b1, 0, 0, 0, 1023, "R6");
        step(1'b1, 0, 1023, 1023, 0, "R6");
        step(1'b1, 0, 1023, 0, 0, "R6");
        step(1'b1, 0, 0, 1023, 1023, "R6");
        flush("R6");
    endtask

    task automatic test_hold();
        step(1'b1, 0, 400, 300, 200, "R9");
        step(1'b0, 0, 1023, 0, 1023, "R9");
        step(1'b0, 0, 0, 1023, 0, "R9");
        step(1'b0, 0, 77, 88, 99, "R9");
        step(1'b1, 0, 10, 20, 30, "R9");
        step(1'b0, 0, 500, 600, 700, "R9");
        flush("R9");
    endtask

    task automatic test_sync();
        step(1'b0, 5, 11, 22, 33, "R8");
        step(1'b1, 2, 44, 55, 66, "R8");
        step(1'b0, 7, 1, 2, 3, "R8");
        step(1'b1, 1, 9, 8, 7, "R8");
        step(1'b0, 4, 0, 0, 0, "R8");
        flush("R8");
    endtask

    task automatic test_latency();
        step(1'b0, 0, 0, 0, 0, "R7");
        step(1'b1, 0, 600, 100, 800, "R7");
        step(1'b0, 0, 0, 0, 0, "R7");
        step(1'b1, 0, 123, 456, 789, "R7");
        step(1'b1, 0, 321, 654, 987, "R7");
        flush("R7");
    endtask

    task automatic test_stream();
        for (int i = 0; i < 300; i++)
            step(1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
                 int'($urandom_range(0, 1023)), "R3");
        flush("R4");
    endtask

    initial begin
        test_reset();
        test_grey();
        test_matrix();
        test_saturate();
        test_hold();
        test_sync();
        test_latency();
        test_stream();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500us;
        total++;
        bad++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule